// File: doc/BRIEF.md
# Metering Front-End Serial Register Port

This block is the serial register port of a single-phase energy-metering front end. A host reaches it over SPI mode 3 while the system clock oversamples the bus. Every transaction starts with a command byte that names a 6-bit register address and a transfer direction. Data bytes follow, most significant byte first. The number of data bytes is fixed by the register addressed: one, two or three.

The block holds three host-writable registers: a control word, an interrupt mask and a calibration word. It also holds a set of measurement registers. A parallel update port, which stands in for the measurement datapath, loads the measurement registers. Waveform samples pass through a decimator selected in the control word. Energy increments are summed into an accumulator. Peak candidates keep the running maximum. Some addresses clear their register as a side effect of a read. An active-low interrupt output reports unmasked status bits.

Top module: `meter_spi_regs`

## Requirements
- R1: The first byte after `spi_cs_n` falls is a command byte. Bit 7 set to 1 selects write and 0 selects read. Bits 5:0 are the address. Bit 6 has no effect.
- R2: Data bytes travel most significant byte first and most significant bit first, in both directions.
- R3: The data length is 3 bytes at 0x01 (sample), 0x02 (energy), 0x03 (energy, read-clear), 0x10 (RMS), 0x11 (peak) and 0x12 (peak, read-clear). It is 2 bytes at 0x08 (control), 0x0A (calibration) and 0x19 (period). It is 1 byte at 0x05 (status), 0x06 (status, read-clear), 0x09 (interrupt mask), 0x18 (temperature) and at every unused address.
- R4: MOSI is sampled on rising SCK edges, which is mode 3. MISO moves to the next bit only after a rising edge, so that bit is stable when the host samples it on the following rising edge. Each SCK phase must last at least 6 `clk` cycles.
- R5: Writing the control word with bit 6 set resets the control word to 0x0000, the interrupt mask to 0x00 and the calibration word to 0x4000. The measurement registers keep their values.
- R6: While control bit 4 is set, every update-port strobe is ignored and the measurement registers hold their values.
- R7: A sample strobe (`upd_sel`=0) is stored only on every (N+1)-th strobe, where N is control bits 12:11. The strobe count restarts at zero on every write to the control word.
- R8: Status bit 3 is set when a sample is stored. Status bit 2 is set when the peak register rises. `irq_n` is low exactly while status AND interrupt mask is nonzero.
- R9: A read of 0x06, 0x03 or 0x12 returns the current value and clears the status, the energy accumulator or the peak register, respectively. The clear happens when the command byte completes. An update arriving in that same cycle is kept.
- R10: The update-port select codes are as follows. With `upd_sel` 1, the data is added to the 24-bit energy accumulator modulo 2^24. With 2, it loads RMS. With 3, the peak becomes the larger of peak and data. With 4, the low 8 bits load temperature. With 5, the low 16 bits load period.
- R11: If `spi_cs_n` rises before the last data bit of a write, the write is discarded.
- R12: Writes to read-only or unused addresses change nothing. Reads of unused addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, idles high |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data, 0 when not reading |
| upd_valid | input | 1 | Update strobe from the measurement datapath |
| upd_sel | input | 3 | Selects which measurement the update targets |
| upd_data | input | 24 | Update value |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Four behaviours are checked on every cycle by properties:
- The bit counter stays within the longest transaction.
- The writable registers change only in a cycle after a completed write.
- A soft reset leaves the default values.
- Power-down freezes the measurement registers, and the interrupt line only falls after an update or a write.

The bench scenarios cover everything that depends on a full serial exchange. These are byte order, per-address lengths, read-clear timing, decimation across all four ratios, aborted writes, and the values returned from unused addresses.

// File: rtl/meter_spi_regs.sv
module meter_spi_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  input  logic        upd_valid,
  input  logic [2:0]  upd_sel,
  input  logic [23:0] upd_data,
  output logic        irq_n
);
  localparam logic [5:0] A_SAMPLE = 6'h01, A_ENERGY = 6'h02, A_ENERGY_RC = 6'h03,
                         A_STAT = 6'h05, A_STAT_RC = 6'h06, A_CTRL = 6'h08,
                         A_MASK = 6'h09, A_CAL = 6'h0A, A_RMS = 6'h10,
                         A_PEAK = 6'h11, A_PEAK_RC = 6'h12, A_TEMP = 6'h18,
                         A_PERIOD = 6'h19;
  localparam logic [15:0] CAL_DEF = 16'h4000;

  function automatic logic [1:0] nbytes(input logic [5:0] a);
    case (a)
      A_SAMPLE, A_ENERGY, A_ENERGY_RC, A_RMS, A_PEAK, A_PEAK_RC: nbytes = 2'd3;
      A_CTRL, A_CAL, A_PERIOD: nbytes = 2'd2;
      default: nbytes = 2'd1;
    endcase
  endfunction

  logic [2:0]  sck_p;
  logic [1:0]  cs_p, mosi_p;
  logic [5:0]  cnt;
  logic [6:0]  sh_cmd;
  logic        cmd_wr, reading;
  logic [5:0]  cmd_addr;
  logic [22:0] dat;
  logic [23:0] tx;

  logic [15:0] mode_r, cal_r, period_r;
  logic [7:0]  irq_en_r, status_r, temp_r;
  logic [23:0] sample_r, energy_r, rms_r, peak_r;
  logic [1:0]  dcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '1; cs_p <= '1; mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], spi_sck};
      cs_p   <= {cs_p[0], spi_cs_n};
      mosi_p <= {mosi_p[0], spi_mosi};
    end

  wire        cs_act   = ~cs_p[1];
  wire        sck_rise = sck_p[1] & ~sck_p[2];
  wire        mosi_b   = mosi_p[1];
  wire [7:0]  cmd_next = {sh_cmd, mosi_b};
  wire [5:0]  ld_addr  = cmd_next[5:0];
  wire        load     = cs_act & sck_rise & (cnt == 6'd7);
  wire        ld_rd    = ~cmd_next[7];
  wire [5:0]  total    = 6'd8 + {1'b0, nbytes(cmd_addr), 3'b000};
  wire [23:0] wr_data  = {dat, mosi_b};
  wire        wr_commit = cs_act & sck_rise & cmd_wr & (cnt >= 6'd8) & (cnt == total - 6'd1);
  wire        soft_rst = wr_commit & (cmd_addr == A_CTRL) & wr_data[6];
  wire        ctrl_wr  = wr_commit & (cmd_addr == A_CTRL);

  wire clr_status = load & ld_rd & (ld_addr == A_STAT_RC);
  wire clr_energy = load & ld_rd & (ld_addr == A_ENERGY_RC);
  wire clr_peak   = load & ld_rd & (ld_addr == A_PEAK_RC);

  logic [23:0] rd_val, ld_tx;
  always_comb begin
    case (ld_addr)
      A_SAMPLE:              rd_val = sample_r;
      A_ENERGY, A_ENERGY_RC: rd_val = energy_r;
      A_STAT, A_STAT_RC:     rd_val = {16'h0, status_r};
      A_CTRL:                rd_val = {8'h0, mode_r};
      A_MASK:                rd_val = {16'h0, irq_en_r};
      A_CAL:                 rd_val = {8'h0, cal_r};
      A_RMS:                 rd_val = rms_r;
      A_PEAK, A_PEAK_RC:     rd_val = peak_r;
      A_TEMP:                rd_val = {16'h0, temp_r};
      A_PERIOD:              rd_val = {8'h0, period_r};
      default:               rd_val = 24'h0;
    endcase
    case (nbytes(ld_addr))
      2'd3:    ld_tx = rd_val;
      2'd2:    ld_tx = {rd_val[15:0], 8'h0};
      default: ld_tx = {rd_val[7:0], 16'h0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; sh_cmd <= '0; cmd_wr <= 1'b0; cmd_addr <= '0;
      dat <= '0; tx <= '0; reading <= 1'b0;
    end else if (!cs_act) begin
      cnt <= '0; tx <= '0; reading <= 1'b0; cmd_wr <= 1'b0;
    end else if (sck_rise) begin
      if (cnt < 6'd7) begin
        sh_cmd <= cmd_next[6:0];
        cnt    <= cnt + 6'd1;
      end else if (cnt == 6'd7) begin
        cmd_wr   <= cmd_next[7];
        cmd_addr <= ld_addr;
        reading  <= ld_rd;
        tx       <= ld_rd ? ld_tx : 24'h0;
        cnt      <= 6'd8;
      end else if (cnt < total) begin
        dat <= wr_data[22:0];
        tx  <= {tx[22:0], 1'b0};
        cnt <= cnt + 6'd1;
      end
    end

  assign spi_miso = cs_act & reading & tx[23];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_r <= '0; irq_en_r <= '0; cal_r <= CAL_DEF;
    end else if (soft_rst) begin
      mode_r <= '0; irq_en_r <= '0; cal_r <= CAL_DEF;
    end else if (wr_commit) begin
      if (cmd_addr == A_CTRL) mode_r   <= wr_data[15:0];
      if (cmd_addr == A_MASK) irq_en_r <= wr_data[7:0];
      if (cmd_addr == A_CAL)  cal_r    <= wr_data[15:0];
    end

  wire upd_ok  = upd_valid & ~mode_r[4];
  wire smp_upd = upd_ok & (upd_sel == 3'd0);
  wire smp_hit = smp_upd & (dcnt >= mode_r[12:11]);
  wire en_upd  = upd_ok & (upd_sel == 3'd1);
  wire [23:0] peak_base = clr_peak ? 24'h0 : peak_r;
  wire pk_hit  = upd_ok & (upd_sel == 3'd3) & (upd_data > peak_base);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dcnt <= '0; sample_r <= '0; energy_r <= '0; rms_r <= '0;
      peak_r <= '0; temp_r <= '0; period_r <= '0; status_r <= '0;
    end else begin
      if (ctrl_wr)      dcnt <= '0;
      else if (smp_upd) dcnt <= smp_hit ? 2'd0 : dcnt + 2'd1;
      if (smp_hit) sample_r <= upd_data;
      if (clr_energy)  energy_r <= en_upd ? upd_data : 24'h0;
      else if (en_upd) energy_r <= energy_r + upd_data;
      if (upd_ok && upd_sel == 3'd2) rms_r    <= upd_data;
      if (upd_ok && upd_sel == 3'd4) temp_r   <= upd_data[7:0];
      if (upd_ok && upd_sel == 3'd5) period_r <= upd_data[15:0];
      peak_r   <= pk_hit ? upd_data : peak_base;
      status_r <= (clr_status ? 8'h0 : status_r) | {4'h0, smp_hit, pk_hit, 2'b00};
    end

  assign irq_n = ~|(status_r & irq_en_r);
endmodule

// File: rtl/meter_spi_regs_chk.sv
module meter_spi_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_valid,
  input logic        irq_n,
  input logic [5:0]  cnt,
  input logic [15:0] mode_r,
  input logic [7:0]  irq_en_r,
  input logic [15:0] cal_r,
  input logic [23:0] rms_r,
  input logic [7:0]  temp_r,
  input logic [15:0] period_r,
  input logic [23:0] sample_r,
  input logic        wr_commit,
  input logic        soft_rst
);
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 6'd32); // R3
  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode_r == 16'h0 && irq_en_r == 8'h0 && cal_r == 16'h4000)); // R5
  AST_PD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_r[4] |=> ($stable(rms_r) && $stable(temp_r) && $stable(period_r) && $stable(sample_r))); // R6
  AST_WR_ONLY_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> ($stable(mode_r) && $stable(irq_en_r) && $stable(cal_r))); // R11
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(upd_valid) || $past(wr_commit))); // R8
endmodule

bind meter_spi_regs meter_spi_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .irq_n(irq_n), .cnt(cnt),
  .mode_r(mode_r), .irq_en_r(irq_en_r), .cal_r(cal_r), .rms_r(rms_r),
  .temp_r(temp_r), .period_r(period_r), .sample_r(sample_r),
  .wr_commit(wr_commit), .soft_rst(soft_rst));

// File: tb/test_meter_spi_regs.sv
module test_meter_spi_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic miso, irq_n;
  logic upd_valid = 1'b0;
  logic [2:0] upd_sel = '0;
  logic [23:0] upd_data = '0;
  int checks = 0, errors = 0;
  logic [23:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  meter_spi_regs i_meter_spi_regs (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .upd_valid(upd_valid), .upd_sel(upd_sel),
    .upd_data(upd_data), .irq_n(irq_n));

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic spi(input logic [7:0] cmd, input int dbits, input logic [23:0] wd,
                     output logic [23:0] r);
    r = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8 + dbits; i++) begin
      sck = 1'b0;
      mosi = (i < 8) ? cmd[7-i] : wd[dbits-1-(i-8)];
      repeat (HALF) @(negedge clk);
      if (i >= 8) r = {r[22:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input int nb, input logic [23:0] v);
    logic [23:0] d;
    spi({2'b10, a}, 8*nb, v, d);
  endtask

  task automatic rdreg(input logic [5:0] a, input int nb, output logic [23:0] v);
    spi({2'b00, a}, 8*nb, 24'h0, v);
  endtask

  task automatic upd(input logic [2:0] s, input logic [23:0] v);
    @(negedge clk); upd_valid = 1'b1; upd_sel = s; upd_data = v;
    @(negedge clk); upd_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R8 reset irq_n", {23'h0, irq_n}, 24'h1);
    chk("R4 idle miso", {23'h0, miso}, 24'h0);
    rdreg(6'h08, 2, rd); chk("R5 reset control", rd, 24'h0);
    rdreg(6'h0A, 2, rd); chk("R5 reset cal", rd, 24'h4000);

    // R7 decimation sweep over all four ratios
    for (int r = 0; r < 4; r++) begin
      int last;
      wr(6'h08, 2, 24'(r << 11));
      for (int k = 1; k <= 7; k++) upd(3'd0, 24'(100 + k));
      last = (7 / (r + 1)) * (r + 1);
      rdreg(6'h01, 3, rd); chk("R7 decimated sample", rd, 24'(100 + last));
    end

    // R8 status and interrupt mask
    chk("R8 masked irq", {23'h0, irq_n}, 24'h1);
    wr(6'h09, 1, 24'h08);
    repeat (4) @(negedge clk);
    chk("R8 unmasked irq", {23'h0, irq_n}, 24'h0);
    rdreg(6'h05, 1, rd); chk("R8 status plain read", rd, 24'h08);
    chk("R9 plain read keeps irq", {23'h0, irq_n}, 24'h0);
    rdreg(6'h06, 1, rd); chk("R9 status read-clear value", rd, 24'h08);
    chk("R9 irq released", {23'h0, irq_n}, 24'h1);
    rdreg(6'h05, 1, rd); chk("R9 status cleared", rd, 24'h0);

    // R10 peak tracking and R9 read-clear
    upd(3'd3, 24'd5); upd(3'd3, 24'd100); upd(3'd3, 24'd50);
    rdreg(6'h11, 3, rd); chk("R10 peak max", rd, 24'd100);
    rdreg(6'h06, 1, rd); chk("R8 peak status bit", rd, 24'h04);
    rdreg(6'h12, 3, rd); chk("R9 peak read-clear value", rd, 24'd100);
    rdreg(6'h11, 3, rd); chk("R9 peak cleared", rd, 24'd0);

    // R10 energy accumulation and R9 read-clear
    upd(3'd1, 24'd1000); upd(3'd1, 24'd2345);
    rdreg(6'h02, 3, rd); chk("R10 energy sum", rd, 24'd3345);
    rdreg(6'h02, 3, rd); chk("R10 energy plain read stable", rd, 24'd3345);
    rdreg(6'h03, 3, rd); chk("R9 energy read-clear value", rd, 24'd3345);
    rdreg(6'h02, 3, rd); chk("R9 energy cleared", rd, 24'd0);
    upd(3'd1, 24'hFFFF00); upd(3'd1, 24'h000200);
    rdreg(6'h02, 3, rd); chk("R10 energy wrap", rd, 24'h000100);

    // R10 other measurements, R2 byte order
    upd(3'd2, 24'h123456); upd(3'd4, 24'hABCD5A); upd(3'd5, 24'hFF8E71);
    rdreg(6'h10, 3, rd); chk("R2 rms msb first", rd, 24'h123456);
    rdreg(6'h18, 1, rd); chk("R10 temp low byte", rd, 24'h5A);
    rdreg(6'h19, 2, rd); chk("R10 period low half", rd, 24'h8E71);

    // R6 power-down
    wr(6'h08, 2, 24'h0010);
    upd(3'd2, 24'h654321); upd(3'd4, 24'h77);
    rdreg(6'h10, 3, rd); chk("R6 rms frozen", rd, 24'h123456);
    rdreg(6'h18, 1, rd); chk("R6 temp frozen", rd, 24'h5A);
    wr(6'h08, 2, 24'h0000);
    upd(3'd2, 24'h654321);
    rdreg(6'h10, 3, rd); chk("R6 rms after power-up", rd, 24'h654321);

    // R1 R2 R3 write/read patterns
    for (int p = 0; p < 4; p++) begin
      logic [15:0] v;
      v = 16'h1234 ^ 16'(p * 16'h2F0B);
      wr(6'h0A, 2, {8'h0, v});
      rdreg(6'h0A, 2, rd); chk("R2 cal roundtrip", rd, {8'h0, v});
    end
    spi(8'h4A, 16, 24'h0, rd);
    chk("R1 bit6 ignored", rd, {8'h0, 16'h1234 ^ 16'(3 * 16'h2F0B)});
    wr(6'h0A, 2, 24'hA55A);
    wr(6'h09, 1, 24'h3C);
    rdreg(6'h09, 1, rd); chk("R3 mask one byte", rd, 24'h3C);
    rdreg(6'h0A, 2, rd); chk("R3 cal two bytes", rd, 24'hA55A);

    // R5 soft reset
    wr(6'h08, 2, 24'h1800);
    wr(6'h08, 2, 24'h0040);
    rdreg(6'h08, 2, rd); chk("R5 control default", rd, 24'h0);
    rdreg(6'h09, 1, rd); chk("R5 mask default", rd, 24'h0);
    rdreg(6'h0A, 2, rd); chk("R5 cal default", rd, 24'h4000);
    rdreg(6'h10, 3, rd); chk("R5 rms kept", rd, 24'h654321);

    // R11 aborted write
    wr(6'h0A, 2, 24'hABCD);
    spi(8'h8A, 12, 24'h0123, rd);
    rdreg(6'h0A, 2, rd); chk("R11 partial write discarded", rd, 24'hABCD);
    wr(6'h0A, 2, 24'h0102);
    rdreg(6'h0A, 2, rd); chk("R11 next write lands", rd, 24'h0102);

    // R12 ignored writes and unused reads
    wr(6'h10, 3, 24'h000000);
    rdreg(6'h10, 3, rd); chk("R12 read-only write ignored", rd, 24'h654321);
    wr(6'h3F, 1, 24'hFF);
    rdreg(6'h0A, 2, rd); chk("R12 unused write ignored", rd, 24'h0102);
    rdreg(6'h3F, 1, rd); chk("R12 unused read zero", rd, 24'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule